// File: doc/BRIEF.md
# Width-Configurable Pattern Step Sequencer

This block sequences the steps of a digital pattern generator. A program counter (PC) walks through step addresses. For each step the block fetches a 32-bit data word and a one-byte control word from external single-port memories, which answer combinationally. It then presents the selected data lanes on a 32-pin output vector. A width mode trades output channels for depth. In 32-channel mode each step consumes a whole data word. In 16-channel mode a step consumes one halfword, which doubles the step count. In 8-channel mode a step consumes one byte, which quadruples it.

One control byte serves a block of 2, 4 or 8 consecutive steps, so one control byte always covers eight data bytes. The upper nibble of the control byte holds per-group disable bits for the four 8-pin groups, and they apply to every step of the block. The lower nibble is an opcode that acts only on the final step of the block. Opcode 1 jumps to the step address held in a host-written register, rounded down to a block start. Every other opcode continues to the next step.

The pin outputs form a fixed-rate stream with no valid/ready handshake. The sequencer cannot be back-pressured, and `run` is the only way to pause it. All other pins are plain control and status. The width mode must only be changed while `srst` is high or `run` is low.

Top module: `pat_step_seq`

## Requirements
- R1: With `srst` high at a clock edge, the PC (`step_addr`) and the jump register both become 0 at that edge.
- R2: While `run` is low, `step_addr` does not change.
- R3: While `run` is high and no jump is taken, `step_addr` increases by one per clock. It wraps to 0 after the last step of the mode's depth: 2^WORD_AW steps in 32-channel mode, twice that in 16-channel mode and four times that in 8-channel mode.
- R4: `mode` 0 selects 32 channels, 1 selects 16 channels and 2 selects 8 channels. `data_addr` is the step address shifted right by 0, 1 or 2 bits. `ctrl_addr` is the step address shifted right by 1, 2 or 3 bits.
- R5: In 32-channel mode the pins carry the whole data word. In 16-channel mode `pins[15:0]` carry bits 15:0 of the word on even steps and bits 31:16 on odd steps. In 8-channel mode `pins[7:0]` carry byte (step mod 4) of the word, with byte 0 in bits 7:0. Pins above the active width are 0.
- R6: `grp_en[g]` is the inverse of control bit 4+g for each active group: groups 0–3 in 32-channel mode, 0–1 in 16-channel mode and 0 in 8-channel mode. Inactive groups read 0. A disabled group drives 0 on `pins[8g+7:8g]`.
- R7: If control bits 3:0 equal 1 on the last step of a block (step offset 1, 3 or 7 within it) while `run` is high, the next step is the jump register limited to the mode's depth and rounded down to a multiple of the block size (2, 4 or 8). The same opcode on any other step of the block has no effect.
- R8: Control opcodes other than 1, including 0, let the PC advance to the next step.
- R9: `rega_we` high loads `rega_wdata` into the jump register at that edge. A jump taken at the same edge uses the previous value.
- R10: `mode` value 3 behaves exactly as 32-channel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| srst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Advance the PC each clock while high |
| mode | input | 2 | Width mode: 0 = 32 ch, 1 = 16 ch, 2 = 8 ch, 3 = 32 ch |
| rega_we | input | 1 | Write strobe for the jump register |
| rega_wdata | input | WORD_AW+2 | Jump register write value (step address) |
| data_addr | output | WORD_AW | Data memory word address |
| data_rd | input | 32 | Data memory read word |
| ctrl_addr | output | WORD_AW-1 | Control memory byte address |
| ctrl_rd | input | 8 | Control memory read byte |
| pins | output | 32 | Gated pattern pins of the current step |
| grp_en | output | 4 | Enable flag per 8-pin group |
| step_addr | output | WORD_AW+2 | Current step address (PC) |

## Verification
The bench sweeps every step of every mode, including the reserved mode value, and checks the lane selection, the group gating and the depth wrap. A design that wrapped at the wrong width would read beyond the installed words or repeat a short loop. A wrong lane order would output halfwords or bytes swapped. Jumps are placed in control blocks with unaligned register values. This catches a design that fires on the first step of a block instead of the last, or that fails to round the target down, because the step trace would then diverge within one block. Writing the jump register on the very edge where a jump fires shows whether the old or the new value is used. Running after a reset with no write shows whether the register was cleared.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [1:0] {
    WM_32  = 2'd0,
    WM_16  = 2'd1,
    WM_8   = 2'd2,
    WM_RSV = 2'd3
  } wmode_e;

  typedef struct packed {
    logic [3:0] dis;  // bit g disables group g
    logic [3:0] op;
  } ctrl_byte_t;

  localparam logic [3:0] OP_CONT = 4'h0;
  localparam logic [3:0] OP_JMPA = 4'h1;

  // log2 of the number of steps packed into one data word
  function automatic logic [1:0] lane_log2(input wmode_e m);
    case (m)
      WM_16:   return 2'd1;
      WM_8:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sseq_ctrl_dec.sv
module sseq_ctrl_dec
  import sseq_pkg::*;
(
  input  logic [7:0] ctrl_rd,
  input  logic [1:0] lg,
  output logic [3:0] grp_en,
  output logic       jmp_op
);

  ctrl_byte_t cb;
  logic [3:0] act;

  always_comb begin
    cb = ctrl_byte_t'(ctrl_rd);
    case (lg)
      2'd1:    act = 4'b0011;
      2'd2:    act = 4'b0001;
      default: act = 4'b1111;
    endcase
    grp_en = ~cb.dis & act;
    jmp_op = (cb.op == OP_JMPA);
  end

endmodule

// File: rtl/sseq_lane_unpack.sv
module sseq_lane_unpack #(
  parameter int WORD_AW = 6,
  localparam int STEP_W = WORD_AW + 2
) (
  input  logic [STEP_W-1:0]  pc,
  input  logic [1:0]         lg,
  input  logic [31:0]        data_rd,
  input  logic [3:0]         grp_en,
  output logic [WORD_AW-1:0] data_addr,
  output logic [31:0]        pins
);

  logic [31:0] raw;

  always_comb begin
    data_addr = WORD_AW'(pc >> lg);
    case (lg)
      2'd1:    raw = {16'h0, pc[0] ? data_rd[31:16] : data_rd[15:0]};
      2'd2:    raw = {24'h0, data_rd[8*pc[1:0] +: 8]};
      default: raw = data_rd;
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : g_gate
    assign pins[8*g +: 8] = grp_en[g] ? raw[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/sseq_pc.sv
module sseq_pc #(
  parameter int WORD_AW = 6,
  localparam int STEP_W = WORD_AW + 2
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              run,
  input  logic [1:0]        lg,
  input  logic              jmp_op,
  input  logic [STEP_W-1:0] rega,
  output logic [STEP_W-1:0] pc,
  output logic              blk_last
);

  logic [STEP_W-1:0] depth_mask, blk_mask, pc_inc, pc_jmp;
  logic              take;

  always_comb begin
    depth_mask = {STEP_W{1'b1}} >> (2'd2 - lg);
    blk_mask   = (STEP_W'(1) << ({1'b0, lg} + 3'd1)) - STEP_W'(1);
    blk_last   = (pc & blk_mask) == blk_mask;
    take       = run & blk_last & jmp_op;
    pc_inc     = (pc + STEP_W'(1)) & depth_mask;
    pc_jmp     = rega & depth_mask & ~blk_mask;
  end

  always_ff @(posedge clk) begin
    if (srst)     pc <= '0;
    else if (run) pc <= take ? pc_jmp : pc_inc;
  end

  p_pc_clear_r1: assert property (@(posedge clk) srst |=> pc == '0);

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (srst)
    !run |=> $stable(pc));

  p_pc_step_r3: assert property (@(posedge clk) disable iff (srst)
    (run && !take) |=> (pc == $past(pc) + STEP_W'(1)) || (pc == '0));

  p_jump_aligned_r7: assert property (@(posedge clk) disable iff (srst)
    (run && take) |=> (pc & $past(blk_mask)) == '0);

endmodule

// File: rtl/pat_step_seq.sv
module pat_step_seq
  import sseq_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  logic                 clk,
  input  logic                 srst,
  input  logic                 run,
  input  logic [1:0]           mode,
  input  logic                 rega_we,
  input  logic [WORD_AW+1:0]   rega_wdata,
  output logic [WORD_AW-1:0]   data_addr,
  input  logic [31:0]          data_rd,
  output logic [WORD_AW-2:0]   ctrl_addr,
  input  logic [7:0]           ctrl_rd,
  output logic [31:0]          pins,
  output logic [3:0]           grp_en,
  output logic [WORD_AW+1:0]   step_addr
);

  localparam int STEP_W  = WORD_AW + 2;
  localparam int CTRL_AW = WORD_AW - 1;

  logic [1:0]        lg;
  logic [STEP_W-1:0] rega_q;
  logic [STEP_W-1:0] pc;
  logic              jmp_op;
  logic              blk_last;

  assign lg        = lane_log2(wmode_e'(mode));
  assign ctrl_addr = CTRL_AW'(pc >> ({1'b0, lg} + 3'd1));
  assign step_addr = pc;

  always_ff @(posedge clk) begin
    if (srst)         rega_q <= '0;
    else if (rega_we) rega_q <= rega_wdata;
  end

  sseq_ctrl_dec u_dec (
    .ctrl_rd (ctrl_rd),
    .lg      (lg),
    .grp_en  (grp_en),
    .jmp_op  (jmp_op)
  );

  sseq_pc #(.WORD_AW(WORD_AW)) u_pc (
    .clk      (clk),
    .srst     (srst),
    .run      (run),
    .lg       (lg),
    .jmp_op   (jmp_op),
    .rega     (rega_q),
    .pc       (pc),
    .blk_last (blk_last)
  );

  sseq_lane_unpack #(.WORD_AW(WORD_AW)) u_unpack (
    .pc        (pc),
    .lg        (lg),
    .data_rd   (data_rd),
    .grp_en    (grp_en),
    .data_addr (data_addr),
    .pins      (pins)
  );

  p_rega_clear_r1: assert property (@(posedge clk) srst |=> rega_q == '0);

  p_rega_load_r9: assert property (@(posedge clk) disable iff (srst)
    rega_we |=> rega_q == $past(rega_wdata));

  // R4: one control byte always spans two data words
  p_ctrl_pairs_word_r4: assert property (@(posedge clk) disable iff (srst)
    ctrl_addr == data_addr[WORD_AW-1:1]);

  p_narrow_groups_r6: assert property (@(posedge clk) disable iff (srst)
    (lg != 2'd0) |-> (grp_en[3:2] == 2'b00 && pins[31:16] == 16'h0));

  for (genvar g = 0; g < 4; g++) begin : g_chk
    p_off_group_quiet_r6: assert property (@(posedge clk) disable iff (srst)
      !grp_en[g] |-> pins[8*g +: 8] == 8'h00);
  end

  // R7: a jump only ever leaves from the final step of a block
  p_jump_from_last_r7: assert property (@(posedge clk) disable iff (srst)
    (run && !blk_last) |=> (pc == $past(pc) + STEP_W'(1)) || (pc == '0));

endmodule

// File: tb/pat_step_seq_tb.sv
module pat_step_seq_tb;

  localparam int WORD_AW = 6;
  localparam int STEP_W  = WORD_AW + 2;

  logic              clk = 1'b0;
  logic              srst = 1'b1;
  logic              run = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic              rega_we = 1'b0;
  logic [STEP_W-1:0] rega_wdata = '0;
  logic [WORD_AW-1:0] data_addr;
  logic [31:0]       data_rd;
  logic [WORD_AW-2:0] ctrl_addr;
  logic [7:0]        ctrl_rd;
  logic [31:0]       pins;
  logic [3:0]        grp_en;
  logic [STEP_W-1:0] step_addr;

  logic [7:0] ctrl_mem [32];
  int exp_pc;
  int ra_m;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] dword(input int w);
    return {8'(w * 7 + 3), 8'(w * 5 + 2) ^ 8'h3C, 8'(w * 3 + 1), 8'(w) ^ 8'hA5};
  endfunction

  assign data_rd = dword(int'(data_addr));
  assign ctrl_rd = ctrl_mem[ctrl_addr];

  pat_step_seq #(.WORD_AW(WORD_AW)) u_dut (
    .clk(clk), .srst(srst), .run(run), .mode(mode),
    .rega_we(rega_we), .rega_wdata(rega_wdata),
    .data_addr(data_addr), .data_rd(data_rd),
    .ctrl_addr(ctrl_addr), .ctrl_rd(ctrl_rd),
    .pins(pins), .grp_en(grp_en), .step_addr(step_addr)
  );

  function automatic int lg_of(input logic [1:0] m);
    return (m == 2'd1) ? 1 : (m == 2'd2) ? 2 : 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (step %0d)", tag, got, exp, exp_pc);
    end
  endtask

  task automatic check_outputs(input string tag);
    int lg = lg_of(mode);
    logic [31:0] d = dword(exp_pc >> lg);
    logic [7:0]  cb = ctrl_mem[exp_pc >> (lg + 1)];
    logic [31:0] raw;
    logic [3:0]  en;
    logic [31:0] ep;
    if (lg == 0)      raw = d;
    else if (lg == 1) raw = (d >> ((exp_pc % 2) * 16)) & 32'h0000_FFFF;
    else              raw = (d >> ((exp_pc % 4) * 8)) & 32'h0000_00FF;
    en = ~cb[7:4] & 4'((1 << (4 >> lg)) - 1);
    for (int g = 0; g < 4; g++) ep[8*g +: 8] = en[g] ? raw[8*g +: 8] : 8'h00;
    chk({tag, " step_addr"}, 32'(step_addr), 32'(exp_pc));
    chk("R4 data_addr", 32'(data_addr), 32'(exp_pc >> lg));
    chk("R4 ctrl_addr", 32'(ctrl_addr), 32'(exp_pc >> (lg + 1)));
    chk("R5/R6 pins", pins, ep);
    chk("R6 grp_en", 32'(grp_en), 32'(en));
  endtask

  task automatic cycle(input logic r, input logic we, input int wd, input string tag);
    int lg, blk, depth, nxt;
    logic [7:0] cb;
    check_outputs(tag);
    lg = lg_of(mode);
    blk = 2 << lg;
    depth = 64 << lg;
    cb = ctrl_mem[exp_pc >> (lg + 1)];
    if (!r) nxt = exp_pc;
    else if ((exp_pc % blk) == blk - 1 && cb[3:0] == 4'h1) nxt = ((ra_m % depth) / blk) * blk;
    else nxt = (exp_pc + 1) % depth;
    run = r; rega_we = we; rega_wdata = STEP_W'(wd);
    @(posedge clk);
    @(negedge clk);
    exp_pc = nxt;
    if (we) ra_m = wd;
    rega_we = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    srst = 1'b1; run = 1'b0; mode = m;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    srst = 1'b0;
    exp_pc = 0; ra_m = 0;
    chk("R1 step_addr after reset", 32'(step_addr), 32'd0);
  endtask

  task automatic fill_cont(input int seed);
    for (int i = 0; i < 32; i++) begin
      logic [3:0] op = (i % 4 == 0) ? 4'h0 : 4'(2 + (i * 3) % 14);
      ctrl_mem[i] = {4'(i * 5 + seed), op};
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (R1..R10 run): actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) ctrl_mem[i] = 8'h00;
    exp_pc = 0; ra_m = 0;

    // R3, R5, R6, R8, R10: full sweep of each mode, wrap included
    for (int m = 0; m < 4; m++) begin
      fill_cont(m);
      do_reset(2'(m));
      for (int c = 0; c < (64 << lg_of(2'(m))) + 6; c++)
        cycle(1'b1, 1'b0, 0, (m == 3) ? "R10" : "R3");
    end

    // R2: stop and restart
    fill_cont(7);
    do_reset(2'd1);
    for (int c = 0; c < 10; c++) cycle(1'b1, 1'b0, 0, "R3");
    for (int c = 0; c < 6; c++)  cycle(1'b0, 1'b0, 0, "R2");
    for (int c = 0; c < 10; c++) cycle(1'b1, 1'b0, 0, "R3");

    // R7: jumps through an unaligned register value in each width mode
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 32; i++) ctrl_mem[i] = 8'h00;
      ctrl_mem[3] = 8'hC1;
      ctrl_mem[9] = 8'h51;
      do_reset(2'(m));
      cycle(1'b0, 1'b1, 45, "R9");
      for (int c = 0; c < 220; c++) cycle(1'b1, 1'b0, 0, "R7");
    end

    // R9: write on the very edge a jump fires
    for (int i = 0; i < 32; i++) ctrl_mem[i] = 8'h20;
    ctrl_mem[3] = 8'hC1;
    do_reset(2'd0);
    cycle(1'b0, 1'b1, 45, "R9");
    for (int c = 0; c < 7; c++) cycle(1'b1, 1'b0, 0, "R9");
    cycle(1'b1, 1'b1, 21, "R9");
    for (int c = 0; c < 20; c++) cycle(1'b1, 1'b0, 0, "R9");

    // R1: reset clears the jump register, so the jump returns to step 0
    do_reset(2'd0);
    for (int c = 0; c < 12; c++) cycle(1'b1, 1'b0, 0, "R1");

    finish_run();
  end

endmodule